// File: doc/BRIEF.md
# CPU PLL Retune Sequencer

This block moves the CPU system PLL to a new frequency without letting the CPU clock glitch. A requester presents a target rate in Hz and pulses start. The block derives the multiplier and output-divider codes from the band the target falls in, and it checks that the CPU clock path is routed through the PLL. It then moves the final CPU clock mux to the 24 MHz crystal and holds it there for a settling time proportional to the old rate. After that it rewrites the PLL control word and switches the CPU back to the PLL. It repeats the write-and-switch step until the PLL reports lock.

The block owns the PLL control word and the CPU clock control word, and shows both on read-only outputs. All fields it does not drive keep their reset contents. The analog PLL lies outside the block and is seen only through its lock input. A lock timeout ends the retry loop and leaves the CPU running from the crystal. The current rate is tracked inside the block, is shown on an output, and changes only when a retune succeeds.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, the PLL word bits 30:0 hold RST_PLL_CTRL and the CPU word holds RST_CPU_CTRL. busy_o and done_o are low, and cur_hz_o equals RST_RATE_HZ.
- R2: The base multiplier is target_hz_i / 24e6, using integer division. Below 600e6 the output-divider code (PLL bits 17:16) is 2 and the multiplier (bits 8:0) is base×4. From 600e6 up to but not including 1200e6 the code is 1 and the multiplier is base×2. At 1200e6 and above the code is 0 and the multiplier is base. The input divider (bits 14:9) is written as 1.
- R3: A retune changes only PLL bits 17:16, 14:9 and 8:0, and only CPU bit 7. All other bits, including the per-core soft resets in CPU bits 27:24, keep their values.
- R4: A request whose target equals cur_hz_o completes with done_o one cycle after acceptance. err_o is low, busy_o never rises and no register changes. This holds even when the clock path fails the R5 check.
- R5: The clock path is valid only when CPU bit 7 = 1, bits 1:0 = 01 and bits 3:2 = 00. Otherwise a request for a new rate completes after one cycle with err_o high and leaves both words unchanged.
- R6: On a valid request, CPU bit 7 clears at acceptance and stays clear for exactly W+3 cycles. W = (100×old_rate/24e6)×CYC_PER_US.
- R7: The PLL word changes only while CPU bit 7 is 0. Bit 7 is set one cycle after each PLL write.
- R8: pll_ctrl_o bit 31 mirrors pll_lock_i. A success completion happens only after lock is sampled high, and the write-and-switch step repeats while lock is low.
- R9: If lock is not seen within LOCK_TMO cycles of the first PLL write, the request ends with err_o high. CPU bit 7 is left at 0 and cur_hz_o is unchanged.
- R10: On success, cur_hz_o becomes 24e6×multiplier / 2^code.
- R11: A request is accepted only when start_i is high and busy_o is low, so start_i is ignored while busy. done_o is a one-cycle pulse, and err_o is high only together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe |
| target_hz_i | input | 32 | Requested rate in Hz |
| pll_lock_i | input | 1 | PLL lock status |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Error, valid with done_o |
| pll_ctrl_o | output | 32 | PLL control word |
| cpu_ctrl_o | output | 32 | CPU clock control word |
| cur_hz_o | output | 32 | Tracked current rate in Hz |

## Verification
On every cycle, the assertions check the ordering rule that the PLL word only moves while the CPU is parked on the crystal. They also check that bits outside CPU bit 7 never move, that done_o lasts one cycle with err_o only beside it, and that success follows a sampled lock. The settling length, the band-to-code mapping, the rate tracking and the timeout can only be shown by the bench's scenarios. The same holds for the precedence of the equal-rate shortcut over the path check and for a start that arrives while a sequence is in flight.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PARK, ST_PROG, ST_SWITCH, ST_CHECK
  } seq_state_e;

  localparam int unsigned OD_LSB  = 16;
  localparam int unsigned DIV_LSB = 9;
  localparam int unsigned MUL_W   = 9;
  localparam int unsigned OD_W    = 2;
  localparam int unsigned DIV_W   = 6;
  localparam int unsigned CPU_SEL_BIT = 7;
endpackage

// File: rtl/retune_calc.sv
module retune_calc
  import pll_retune_pkg::*;
#(
  parameter int unsigned REF_HZ      = 24_000_000,
  parameter int unsigned CYC_PER_US  = 24,
  parameter int unsigned LOW_BAND_HZ = 600_000_000,
  parameter int unsigned MID_BAND_HZ = 1_200_000_000,
  parameter int unsigned WAIT_W      = 32
) (
  input  logic [31:0]       target_hz_i,
  input  logic [31:0]       old_hz_i,
  output logic [MUL_W-1:0]  mul_o,
  output logic [OD_W-1:0]   od_o,
  output logic [31:0]       new_hz_o,
  output logic [WAIT_W-1:0] wait_cyc_o
);
  logic [31:0] base;

  always_comb begin
    base = target_hz_i / REF_HZ;
    if (target_hz_i < LOW_BAND_HZ) begin
      od_o  = 2'd2;
      mul_o = MUL_W'(base << 2);
    end else if (target_hz_i < MID_BAND_HZ) begin
      od_o  = 2'd1;
      mul_o = MUL_W'(base << 1);
    end else begin
      od_o  = 2'd0;
      mul_o = MUL_W'(base);
    end
  end

  // input divider fixed at 1
  assign new_hz_o   = 32'((64'(REF_HZ) * 64'(mul_o)) >> od_o);
  assign wait_cyc_o = WAIT_W'(((64'(old_hz_i) * 64'd100) / 64'(REF_HZ)) * 64'(CYC_PER_US));
endmodule

// File: rtl/retune_timer.sv
module retune_timer #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_retune_pkg::*;
#(
  parameter int unsigned REF_HZ       = 24_000_000,
  parameter int unsigned CYC_PER_US   = 24,
  parameter int unsigned LOCK_TMO     = 65536,
  parameter logic [31:0] RST_PLL_CTRL = 32'h4010_0232,
  parameter logic [31:0] RST_CPU_CTRL = 32'h0A00_0081,
  parameter int unsigned RST_RATE_HZ  = 1_200_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] target_hz_i,
  input  logic        pll_lock_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] pll_ctrl_o,
  output logic [31:0] cpu_ctrl_o,
  output logic [31:0] cur_hz_o
);
  localparam int unsigned WAIT_W = 32;
  localparam int unsigned TMO_W  = $clog2(LOCK_TMO + 1);
  localparam logic [30:0] FIELD_MASK =
      (31'((1 << OD_W) - 1) << OD_LSB) | (31'((1 << DIV_W) - 1) << DIV_LSB) | 31'((1 << MUL_W) - 1);

  seq_state_e        state_q;
  logic [30:0]       pll_q, pll_next_q;
  logic [31:0]       cpu_q, cur_q, new_rate_q;
  logic              done_q, err_q;

  logic [MUL_W-1:0]  c_mul;
  logic [OD_W-1:0]   c_od;
  logic [31:0]       c_rate;
  logic [WAIT_W-1:0] c_wait;
  logic              settle_zero, tmo_zero;
  logic              accept, same_rate, path_ok, go;

  retune_calc #(
    .REF_HZ(REF_HZ), .CYC_PER_US(CYC_PER_US), .WAIT_W(WAIT_W)
  ) u_calc (
    .target_hz_i(target_hz_i), .old_hz_i(cur_q),
    .mul_o(c_mul), .od_o(c_od), .new_hz_o(c_rate), .wait_cyc_o(c_wait)
  );

  assign accept    = start_i && (state_q == ST_IDLE);
  assign same_rate = (target_hz_i == cur_q);
  assign path_ok   = cpu_q[CPU_SEL_BIT] && (cpu_q[1:0] == 2'b01) && (cpu_q[3:2] == 2'b00);
  assign go        = accept && !same_rate && path_ok;

  retune_timer #(.W(WAIT_W)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(go), .val_i(c_wait),
    .dec_i(state_q == ST_PARK), .zero_o(settle_zero)
  );

  retune_timer #(.W(TMO_W)) u_tmo (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i((state_q == ST_PARK) && settle_zero), .val_i(TMO_W'(LOCK_TMO)),
    .dec_i(state_q inside {ST_PROG, ST_SWITCH, ST_CHECK}), .zero_o(tmo_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      pll_q      <= RST_PLL_CTRL[30:0];
      pll_next_q <= RST_PLL_CTRL[30:0];
      cpu_q      <= RST_CPU_CTRL;
      cur_q      <= RST_RATE_HZ;
      new_rate_q <= RST_RATE_HZ;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          if (same_rate) begin
            done_q <= 1'b1;
          end else if (!path_ok) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            cpu_q[CPU_SEL_BIT] <= 1'b0;  // park on crystal
            pll_next_q <= (pll_q & ~FIELD_MASK)
                        | (31'(c_od) << OD_LSB) | (31'(1) << DIV_LSB) | 31'(c_mul);
            new_rate_q <= c_rate;
            state_q    <= ST_PARK;
          end
        end
        ST_PARK:   if (settle_zero) state_q <= ST_PROG;
        ST_PROG: begin
          pll_q   <= pll_next_q;
          state_q <= ST_SWITCH;
        end
        ST_SWITCH: begin
          cpu_q[CPU_SEL_BIT] <= 1'b1;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (pll_lock_i) begin
            done_q  <= 1'b1;
            cur_q   <= new_rate_q;
            state_q <= ST_IDLE;
          end else if (tmo_zero) begin
            cpu_q[CPU_SEL_BIT] <= 1'b0;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PROG;  // retry write-and-switch
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign pll_ctrl_o = {pll_lock_i, pll_q};
  assign cpu_ctrl_o = cpu_q;
  assign cur_hz_o   = cur_q;

  a_r7_pll_write_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pll_q) |-> !cpu_q[CPU_SEL_BIT]);
  a_r3_cpu_rmw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(cpu_q[31:8]) && $stable(cpu_q[6:0]));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r11_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> done_q);
  a_r8_success_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !err_q && $past(state_q == ST_CHECK)) |-> $past(pll_lock_i));
  a_r7_switch_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SWITCH) |=> cpu_q[CPU_SEL_BIT]);
endmodule

// File: tb/sim_pll_retune_seq.sv
module sim_pll_retune_seq;
  localparam logic [31:0] PLL0  = 32'h4010_0232;
  localparam logic [31:0] CPU0  = 32'h0A00_0081;
  localparam int unsigned RATE0 = 1_200_000_000;
  localparam int unsigned TMO   = 400;
  localparam int unsigned LOCK_DLY = 6;
  localparam int unsigned N_VEC = 4;
  localparam int unsigned V_TGT [N_VEC] = '{792_000_000, 408_000_000, 1_512_000_000, 600_000_000};
  localparam int unsigned V_MUL [N_VEC] = '{66, 68, 63, 50};
  localparam int unsigned V_OD  [N_VEC] = '{1, 2, 0, 1};
  localparam int unsigned V_WAIT[N_VEC] = '{5000, 3300, 1700, 6300};

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, pll_lock_i = 1'b1;
  logic [31:0] target_hz_i = '0;
  logic busy_o, done_o, err_o;
  logic [31:0] pll_ctrl_o, cpu_ctrl_o, cur_hz_o;

  int n_chk = 0, n_err = 0;
  int lat, low, busy_seen, got_done;
  bit force_low = 1'b0;
  int lk_cnt = 0;
  logic [17:0] last_pll = '0;

  always #4 clk_i = ~clk_i;

  pll_retune_seq #(.CYC_PER_US(1), .LOCK_TMO(TMO), .RST_PLL_CTRL(PLL0),
                   .RST_CPU_CTRL(CPU0), .RST_RATE_HZ(RATE0)) u0 (.*);

  // PLL model: drops lock for LOCK_DLY cycles after any field change
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      lk_cnt = 0;
    end else begin
      if (pll_ctrl_o[17:0] != last_pll) lk_cnt = LOCK_DLY;
      else if (lk_cnt != 0) lk_cnt = lk_cnt - 1;
    end
    last_pll   = pll_ctrl_o[17:0];
    pll_lock_i = !force_low && (lk_cnt == 0);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] tgt, input bit poke);
    @(negedge clk_i);
    target_hz_i = tgt;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0; low = 0; busy_seen = 0; got_done = 0;
    for (int k = 0; k < 20000; k++) begin
      lat++;
      if (!cpu_ctrl_o[7]) low++;
      if (busy_o) busy_seen = 1;
      if (done_o) begin got_done = 1; break; end
      if (poke && k == 10) begin
        target_hz_i = 32'd1_512_000_000;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(got_done == 1, "R11", "done seen (watchdog)", got_done, 1);
  endtask

  function automatic logic [30:0] exp_pll(input int unsigned mul, input int unsigned od);
    logic [31:0] w;
    w = PLL0 & ~32'h0003_7FFF;
    w = w | (32'(od) << 16) | (32'd1 << 9) | 32'(mul);
    return w[30:0];
  endfunction

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(pll_ctrl_o[30:0] == PLL0[30:0], "R1", "pll word", pll_ctrl_o[30:0], PLL0[30:0]);
    chk(cpu_ctrl_o == CPU0, "R1", "cpu word", cpu_ctrl_o, CPU0);
    chk(!busy_o && !done_o, "R1", "busy/done", {busy_o, done_o}, 0);
    chk(cur_hz_o == RATE0, "R1", "rate", cur_hz_o, RATE0);
    rst_ni = 1'b1;

    // R4 equal rate from reset
    run_req(RATE0, 1'b0);
    chk(lat == 1 && !err_o && busy_seen == 0, "R4", "immediate ok", lat, 1);
    chk(pll_ctrl_o[30:0] == PLL0[30:0] && cpu_ctrl_o == CPU0, "R4", "no change",
        pll_ctrl_o[30:0], PLL0[30:0]);

    for (int i = 0; i < N_VEC; i++) begin
      run_req(V_TGT[i], i == 1);
      chk(!err_o, "R11", "err low on success", err_o, 0);
      chk(low == V_WAIT[i] + 3, "R6", "park length", low, V_WAIT[i] + 3);
      chk(lat >= V_WAIT[i] + 3 + LOCK_DLY && pll_ctrl_o[31], "R8", "waited for lock",
          lat, V_WAIT[i] + 3 + LOCK_DLY);
      chk(pll_ctrl_o[30:0] == exp_pll(V_MUL[i], V_OD[i]), "R2", "pll codes",
          pll_ctrl_o[30:0], exp_pll(V_MUL[i], V_OD[i]));
      chk(cpu_ctrl_o == CPU0, "R3", "cpu word preserved", cpu_ctrl_o, CPU0);
      chk(cur_hz_o == (64'(24_000_000) * V_MUL[i]) >> V_OD[i], "R10", "rate",
          cur_hz_o, (64'(24_000_000) * V_MUL[i]) >> V_OD[i]);
      @(negedge clk_i);
      chk(!done_o, "R11", "done one cycle", done_o, 0);
    end

    // R9 lock timeout
    force_low = 1'b1;
    run_req(32'd960_000_000, 1'b0);
    chk(err_o == 1'b1, "R9", "timeout error", err_o, 1);
    chk(cpu_ctrl_o == (CPU0 & ~32'h80), "R9", "cpu parked", cpu_ctrl_o, CPU0 & ~32'h80);
    chk(cur_hz_o == 32'd600_000_000, "R9", "rate kept", cur_hz_o, 600_000_000);
    chk(pll_ctrl_o[30:0] == exp_pll(80, 1), "R2", "written before timeout",
        pll_ctrl_o[30:0], exp_pll(80, 1));
    force_low = 1'b0;
    repeat (LOCK_DLY + 2) @(negedge clk_i);

    // R5 bad clock path
    run_req(RATE0, 1'b0);
    chk(err_o == 1'b1 && lat == 1, "R5", "path error", err_o, 1);
    chk(pll_ctrl_o[30:0] == exp_pll(80, 1) && cpu_ctrl_o == (CPU0 & ~32'h80), "R5",
        "no change", pll_ctrl_o[30:0], exp_pll(80, 1));

    // R4 equal rate wins over bad path
    run_req(32'd600_000_000, 1'b0);
    chk(!err_o && lat == 1 && busy_seen == 0, "R4", "equal with bad path", err_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule